// File: doc/BRIEF.md
# Segment Hash and Fault Encoder

This block performs the segment stage of a hashed-page-table translation once no block mapping has matched. Sixteen segment registers, written through a simple write port, are indexed by the top four bits of the effective address. The selected register supplies the protection key, a direct-store flag, a no-execute flag and a 24-bit virtual segment id. From these and the page index the block forms the primary hash, the compare tag used against table entries, and the byte addresses of the primary and secondary 64-byte entry groups in the hashed table.

The caller presents each request together with the outcome of its own TLB lookup: hit or miss, and whether the hit grants the access. The block classifies the outcome as success, direct-store access, miss or protection fault, and encodes the exception class, the error code, the status word, the faulting address and the compare word. Results are registered. A fault stays on the outputs until the core acknowledges it, and new requests are refused while it is pending. The table walk itself is done elsewhere, using the two group addresses produced here.

Top module: `seg_hash_fault`

## Requirements
- R1: While reset is asserted and until the first accepted request, every output is zero.
- R2: The segment register is chosen by ea_i[31:28]. In a segment word, bit 31 is the direct-store flag, bit 30 the supervisor key, bit 29 the user key, bit 28 no-execute, and bits 23:0 the virtual segment id. key_o is the user key when user_i is 1 and the supervisor key otherwise.
- R3: With page index p = ea_i[27:12] and segment id v, the hash is v XOR p. tag_o = (v << 7) | (p >> 10).
- R4: grp1_o = tbl_base_i | ((hash[18:0] & tbl_mask_i) << 6). grp2_o uses the one's complement of hash[18:0] in place of the hash.
- R5: A fetch (acc_i = 2) to a segment whose no-execute or direct-store flag is set gives excp_o = 4 and err_o = 0x10000000, whatever the lookup result.
- R6: A fetch miss gives excp_o = 1. err_o has bit 18 set and the key at bit 19. far_o equals the address, and cmp_o = 0x80000000 | tag.
- R7: A data miss gives excp_o = 3 for a store (acc_i = 1), with err_o bit 16 set, and excp_o = 2 for a load (acc_i = 0 or 3). The key is placed at err_o bit 19, far_o equals the address, and cmp_o = 0x80000000 | tag.
- R8: A hit without permission gives, for data, excp_o = 5, err_o = 0, far_o equal to the address, and stat_o = 0x0A000000 for a store or 0x08000000 for a load. For a fetch it gives excp_o = 4 and err_o = 0x08000000.
- R9: A permitted hit in an ordinary segment completes with fault_o = 0, excp_o = 0, ds_o = 0 and err_o, stat_o, far_o and cmp_o all zero.
- R10: A data access to a direct-store segment ignores the lookup. It succeeds with ds_o = 1 when it is a store with key 1 or a load with key 0. Otherwise it raises the data protection fault of R8.
- R11: done_o is high in the cycle after each accepted request and only then. All result outputs update at that same edge.
- R12: fault_o stays high, with the results unchanged, until ack_i is sampled high. It clears at that edge. Requests presented while fault_o is high are not accepted.
- R13: A segment write takes effect at the next edge. A request in the same cycle as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_we_i | input | 1 | Segment register write enable |
| seg_widx_i | input | 4 | Segment register index to write |
| seg_wdata_i | input | 32 | Segment register write data |
| tbl_base_i | input | 32 | Hashed table base address |
| tbl_mask_i | input | 19 | Mask applied to the hash before it is scaled to a group offset |
| req_valid_i | input | 1 | Translation request |
| ea_i | input | 32 | Effective address |
| acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| user_i | input | 1 | 1 for user state, 0 for supervisor state |
| tlb_hit_i | input | 1 | TLB lookup found a matching entry |
| tlb_perm_ok_i | input | 1 | Matching entry grants this access |
| ack_i | input | 1 | Acknowledge of a pending fault |
| done_o | output | 1 | Result valid, one cycle |
| fault_o | output | 1 | Fault pending |
| excp_o | output | 3 | Exception class (0 none, 1 fetch miss, 2 load miss, 3 store miss, 4 fetch protection, 5 data protection) |
| err_o | output | 32 | Error code |
| stat_o | output | 32 | Data fault status word |
| far_o | output | 32 | Captured faulting address |
| cmp_o | output | 32 | Compare word for the miss handler |
| key_o | output | 1 | Selected protection key |
| ds_o | output | 1 | Access completed as direct-store |
| tag_o | output | 31 | Compare tag |
| grp1_o | output | 32 | Primary entry group address |
| grp2_o | output | 32 | Secondary entry group address |

## Verification
The assertions check several rules on every cycle. A pending fault is held and refuses new work. done_o follows a request. A clean completion carries no exception class. Every miss sets the compare flag and captures the address that was presented. A fetch protection fault carries one of its two legal error codes. The exact hash, tag, group addresses, error bits and status words depend on the segment contents and the address. Only the bench's reference model and its directed cases can show these, including the key choice by privilege, the direct-store permission rule and a write colliding with a request to the same segment.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_LOAD2 = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    XC_NONE  = 3'd0,
    XC_IMISS = 3'd1,
    XC_LMISS = 3'd2,
    XC_SMISS = 3'd3,
    XC_IPROT = 3'd4,
    XC_DPROT = 3'd5
  } xc_e;

  // segment word field positions
  localparam int SR_T  = 31;
  localparam int SR_KS = 30;
  localparam int SR_KP = 29;
  localparam int SR_N  = 28;

  localparam int ERR_SMISS_B = 16;
  localparam int ERR_IMISS_B = 18;
  localparam int ERR_KEY_B   = 19;

  localparam logic [31:0] ERR_IPROT  = 32'h0800_0000;
  localparam logic [31:0] ERR_NOEXEC = 32'h1000_0000;
  localparam logic [31:0] ST_DSTORE  = 32'h0A00_0000;
  localparam logic [31:0] ST_DLOAD   = 32'h0800_0000;

  typedef struct packed {
    xc_e         xc;
    logic        ds;
    logic        cmp_set;
    logic        cap_addr;
    logic [31:0] err;
    logic [31:0] stat;
  } fault_t;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int NSEG = 16,
  parameter int SR_W = 32,
  localparam int SEL_W = $clog2(NSEG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] widx_i,
  input  logic [SR_W-1:0]  wdata_i,
  input  logic [SEL_W-1:0] ridx_i,
  output logic [SR_W-1:0]  rdata_o
);
  logic [NSEG-1:0]           wen;
  logic [NSEG-1:0][SR_W-1:0] regs_q;

  for (genvar g = 0; g < NSEG; g++) begin : g_wdec
    assign wen[g] = we_i && (widx_i == SEL_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else begin
      for (int i = 0; i < NSEG; i++)
        if (wen[i]) regs_q[i] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[ridx_i];
endmodule

// File: rtl/seg_hash.sv
module seg_hash
  import seg_pkg::*;
#(
  parameter int AW      = 32,
  parameter int SR_W    = 32,
  parameter int VSID_W  = 24,
  parameter int PIDX_W  = 16,
  parameter int PAGE_SH = 12,
  parameter int API_W   = 6,
  parameter int HASH_W  = 19,
  parameter int GRP_SH  = 6,
  localparam int TAG_W  = VSID_W + 1 + API_W
) (
  input  logic [SR_W-1:0]   sr_i,
  input  logic [AW-1:0]     ea_i,
  input  logic              user_i,
  input  logic [AW-1:0]     base_i,
  input  logic [HASH_W-1:0] mask_i,
  output logic              key_o,
  output logic              t_o,
  output logic              n_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [AW-1:0]     grp1_o,
  output logic [AW-1:0]     grp2_o
);
  logic [VSID_W-1:0] vsid;
  logic [PIDX_W-1:0] pidx;
  logic [VSID_W-1:0] hash;
  logic [HASH_W-1:0] h1, h2;

  assign vsid  = sr_i[VSID_W-1:0];
  assign pidx  = ea_i[PAGE_SH +: PIDX_W];
  assign hash  = vsid ^ VSID_W'(pidx);
  assign key_o = user_i ? sr_i[SR_KP] : sr_i[SR_KS];
  assign t_o   = sr_i[SR_T];
  assign n_o   = sr_i[SR_N];
  // bit between segment id and page abbreviation is the secondary-hash flag, zero here
  assign tag_o = {vsid, 1'b0, pidx[PIDX_W-1 -: API_W]};

  assign h1     = hash[HASH_W-1:0] & mask_i;
  assign h2     = ~hash[HASH_W-1:0] & mask_i;
  assign grp1_o = base_i | (AW'(h1) << GRP_SH);
  assign grp2_o = base_i | (AW'(h2) << GRP_SH);
endmodule

// File: rtl/fault_enc.sv
module fault_enc
  import seg_pkg::*;
(
  input  logic [1:0] acc_i,
  input  logic       key_i,
  input  logic       t_i,
  input  logic       n_i,
  input  logic       hit_i,
  input  logic       perm_i,
  output fault_t     res_o
);
  logic is_f, is_s;
  assign is_f = (acc_i == ACC_FETCH);
  assign is_s = (acc_i == ACC_STORE);

  always_comb begin
    res_o          = '0;
    res_o.xc       = XC_NONE;
    if (is_f) begin
      if (t_i || n_i) begin
        res_o.xc  = XC_IPROT;
        res_o.err = ERR_NOEXEC;
      end else if (!hit_i) begin
        res_o.xc              = XC_IMISS;
        res_o.err[ERR_IMISS_B] = 1'b1;
        res_o.err[ERR_KEY_B]   = key_i;
        res_o.cmp_set         = 1'b1;
        res_o.cap_addr        = 1'b1;
      end else if (!perm_i) begin
        res_o.xc  = XC_IPROT;
        res_o.err = ERR_IPROT;
      end
    end else if (t_i) begin
      // direct-store: store needs key set, load needs key clear
      if (is_s ? key_i : !key_i) begin
        res_o.ds = 1'b1;
      end else begin
        res_o.xc       = XC_DPROT;
        res_o.stat     = is_s ? ST_DSTORE : ST_DLOAD;
        res_o.cap_addr = 1'b1;
      end
    end else if (!hit_i) begin
      res_o.xc             = is_s ? XC_SMISS : XC_LMISS;
      res_o.err[ERR_SMISS_B] = is_s;
      res_o.err[ERR_KEY_B]   = key_i;
      res_o.cmp_set        = 1'b1;
      res_o.cap_addr       = 1'b1;
    end else if (!perm_i) begin
      res_o.xc       = XC_DPROT;
      res_o.stat     = is_s ? ST_DSTORE : ST_DLOAD;
      res_o.cap_addr = 1'b1;
    end
  end
endmodule

// File: rtl/seg_hash_fault.sv
module seg_hash_fault
  import seg_pkg::*;
#(
  parameter int AW      = 32,
  parameter int NSEG    = 16,
  parameter int VSID_W  = 24,
  parameter int PAGE_SH = 12,
  parameter int API_W   = 6,
  parameter int HASH_W  = 19,
  parameter int GRP_SH  = 6,
  localparam int SEL_W  = $clog2(NSEG),
  localparam int PIDX_W = AW - SEL_W - PAGE_SH,
  localparam int TAG_W  = VSID_W + 1 + API_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seg_we_i,
  input  logic [SEL_W-1:0]  seg_widx_i,
  input  logic [AW-1:0]     seg_wdata_i,
  input  logic [AW-1:0]     tbl_base_i,
  input  logic [HASH_W-1:0] tbl_mask_i,
  input  logic              req_valid_i,
  input  logic [AW-1:0]     ea_i,
  input  logic [1:0]        acc_i,
  input  logic              user_i,
  input  logic              tlb_hit_i,
  input  logic              tlb_perm_ok_i,
  input  logic              ack_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [2:0]        excp_o,
  output logic [AW-1:0]     err_o,
  output logic [AW-1:0]     stat_o,
  output logic [AW-1:0]     far_o,
  output logic [AW-1:0]     cmp_o,
  output logic              key_o,
  output logic              ds_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [AW-1:0]     grp1_o,
  output logic [AW-1:0]     grp2_o
);
  logic [AW-1:0]    sr_rd;
  logic             key_c, t_c, n_c;
  logic [TAG_W-1:0] tag_c;
  logic [AW-1:0]    g1_c, g2_c, cmp_c;
  fault_t           fr;
  logic             accept;

  seg_regfile #(.NSEG(NSEG), .SR_W(AW)) u_sr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (seg_we_i),
    .widx_i  (seg_widx_i),
    .wdata_i (seg_wdata_i),
    .ridx_i  (ea_i[AW-1 -: SEL_W]),
    .rdata_o (sr_rd)
  );

  seg_hash #(
    .AW(AW), .SR_W(AW), .VSID_W(VSID_W), .PIDX_W(PIDX_W), .PAGE_SH(PAGE_SH),
    .API_W(API_W), .HASH_W(HASH_W), .GRP_SH(GRP_SH)
  ) u_hash (
    .sr_i   (sr_rd),
    .ea_i   (ea_i),
    .user_i (user_i),
    .base_i (tbl_base_i),
    .mask_i (tbl_mask_i),
    .key_o  (key_c),
    .t_o    (t_c),
    .n_o    (n_c),
    .tag_o  (tag_c),
    .grp1_o (g1_c),
    .grp2_o (g2_c)
  );

  fault_enc u_enc (
    .acc_i  (acc_i),
    .key_i  (key_c),
    .t_i    (t_c),
    .n_i    (n_c),
    .hit_i  (tlb_hit_i),
    .perm_i (tlb_perm_ok_i),
    .res_o  (fr)
  );

  always_comb begin
    cmp_c = '0;
    if (fr.cmp_set) begin
      cmp_c[AW-1]      = 1'b1;
      cmp_c[TAG_W-1:0] = tag_c;
    end
  end

  assign accept = req_valid_i && !fault_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      excp_o  <= '0;
      err_o   <= '0;
      stat_o  <= '0;
      far_o   <= '0;
      cmp_o   <= '0;
      key_o   <= 1'b0;
      ds_o    <= 1'b0;
      tag_o   <= '0;
      grp1_o  <= '0;
      grp2_o  <= '0;
    end else begin
      done_o <= accept;
      if (accept) begin
        fault_o <= (fr.xc != XC_NONE);
        excp_o  <= fr.xc;
        err_o   <= fr.err;
        stat_o  <= fr.stat;
        far_o   <= fr.cap_addr ? ea_i : '0;
        cmp_o   <= cmp_c;
        key_o   <= key_c;
        ds_o    <= fr.ds;
        tag_o   <= tag_c;
        grp1_o  <= g1_c;
        grp2_o  <= g2_c;
      end else if (ack_i) begin
        fault_o <= 1'b0;
      end
    end
  end

  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !ack_i |=> fault_o && $stable(excp_o) && $stable(far_o)) else $error("fault hold"); // R12
  AST_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !done_o) else $error("accept while faulted"); // R12
  AST_DONE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(req_valid_i)) else $error("done without request"); // R11
  AST_CLEAN_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> excp_o == XC_NONE) else $error("success with class"); // R9
  AST_FAULT_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> excp_o != XC_NONE) else $error("fault without class"); // R8
  AST_MISS_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (excp_o == XC_IMISS || excp_o == XC_LMISS || excp_o == XC_SMISS)
    |-> cmp_o[AW-1] && far_o == $past(ea_i)) else $error("miss capture"); // R6
  AST_IPROT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && excp_o == XC_IPROT |-> err_o == ERR_IPROT || err_o == ERR_NOEXEC) else $error("fetch prot code"); // R5
endmodule

// File: tb/tb_seg_hash_fault.sv
`timescale 1ns/1ps
module tb_seg_hash_fault;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  widx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] base = '0;
  logic [18:0] mask = '0;
  logic        req = 1'b0;
  logic [31:0] ea = '0;
  logic [1:0]  acc = '0;
  logic        usr = 1'b0;
  logic        hit = 1'b0;
  logic        pok = 1'b0;
  logic        ack = 1'b0;

  logic        done, fault, key, ds;
  logic [2:0]  excp;
  logic [31:0] err, stat, far, cmpw, g1, g2;
  logic [30:0] tag;

  int n_chk = 0;
  int n_bad = 0;
  bit live = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  seg_hash_fault dut (
    .clk_i(clk), .rst_ni(rst_n), .seg_we_i(we), .seg_widx_i(widx), .seg_wdata_i(wdata),
    .tbl_base_i(base), .tbl_mask_i(mask), .req_valid_i(req), .ea_i(ea), .acc_i(acc),
    .user_i(usr), .tlb_hit_i(hit), .tlb_perm_ok_i(pok), .ack_i(ack),
    .done_o(done), .fault_o(fault), .excp_o(excp), .err_o(err), .stat_o(stat),
    .far_o(far), .cmp_o(cmpw), .key_o(key), .ds_o(ds), .tag_o(tag),
    .grp1_o(g1), .grp2_o(g2)
  );

  // reference model
  logic [31:0] sr_m [16];
  logic        m_done, m_fault, m_key, m_ds;
  logic [2:0]  m_xc;
  logic [31:0] m_err, m_stat, m_far, m_cmp, m_g1, m_g2, m_tag;
  logic [31:0] s_v;
  logic [23:0] v_v, h_v;
  logic [15:0] p_v;
  logic        k_v, take;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done = 0; m_fault = 0; m_key = 0; m_ds = 0; m_xc = 0;
      m_err = 0; m_stat = 0; m_far = 0; m_cmp = 0; m_g1 = 0; m_g2 = 0; m_tag = 0;
      for (int i = 0; i < 16; i++) sr_m[i] = 0;
    end else begin
      take = req && !m_fault;
      if (take) begin
        s_v = sr_m[ea[31:28]];
        v_v = s_v[23:0];
        p_v = ea[27:12];
        h_v = v_v ^ {8'h00, p_v};
        k_v = usr ? s_v[29] : s_v[30];
        m_key = k_v;
        m_tag = ({8'h00, v_v} << 7) | ({16'h0, p_v} >> 10);
        m_g1 = base | ((({8'h00, h_v} & 32'h7FFFF) & {13'h0, mask}) << 6);
        m_g2 = base | ((({8'h00, ~h_v} & 32'h7FFFF) & {13'h0, mask}) << 6);
        m_xc = 0; m_err = 0; m_stat = 0; m_far = 0; m_cmp = 0; m_ds = 0;
        if (acc == 2) begin
          if (s_v[31] || s_v[28]) begin m_xc = 4; m_err = 32'h1000_0000; end
          else if (!hit) begin
            m_xc = 1; m_err = 32'h0004_0000 | (32'(k_v) << 19); m_far = ea; m_cmp = 32'h8000_0000 | m_tag;
          end else if (!pok) begin m_xc = 4; m_err = 32'h0800_0000; end
        end else if (s_v[31]) begin
          if ((acc == 1 && k_v) || (acc != 1 && !k_v)) m_ds = 1;
          else begin m_xc = 5; m_far = ea; m_stat = (acc == 1) ? 32'h0A00_0000 : 32'h0800_0000; end
        end else if (!hit) begin
          m_xc = (acc == 1) ? 3'd3 : 3'd2;
          m_err = ((acc == 1) ? 32'h0001_0000 : 32'h0) | (32'(k_v) << 19);
          m_far = ea; m_cmp = 32'h8000_0000 | m_tag;
        end else if (!pok) begin
          m_xc = 5; m_far = ea; m_stat = (acc == 1) ? 32'h0A00_0000 : 32'h0800_0000;
        end
        m_fault = (m_xc != 0);
      end else if (ack) begin
        m_fault = 0;
      end
      m_done = take;
      if (we) sr_m[widx] = wdata;
    end
  end

  task automatic chk(input string rq, input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", rq, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R11", "done", 32'(done), 32'(m_done));
      chk("R12", "fault", 32'(fault), 32'(m_fault));
      chk("R5 R6 R7 R8", "excp", 32'(excp), 32'(m_xc));
      chk("R6 R7", "err", err, m_err);
      chk("R8", "stat", stat, m_stat);
      chk("R8", "far", far, m_far);
      chk("R6", "cmp", cmpw, m_cmp);
      chk("R2", "key", 32'(key), 32'(m_key));
      chk("R10", "ds", 32'(ds), 32'(m_ds));
      chk("R3", "tag", 32'(tag), m_tag);
      chk("R4", "grp1", g1, m_g1);
      chk("R4", "grp2", g2, m_g2);
    end
  end

  task automatic wr_seg(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk); we = 1; widx = i; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic req1(input logic [31:0] a, input logic [1:0] k, input logic u, input logic h, input logic p);
    @(negedge clk); req = 1; ea = a; acc = k; usr = u; hit = h; pok = p;
    @(negedge clk); req = 0;
  endtask

  task automatic ack1();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done", 32'(done), 0);
    chk("R1", "fault", 32'(fault), 0);
    chk("R1", "grp1", g1, 0);
    chk("R1", "cmp", cmpw, 0);
    rst_n = 1'b1;
    live = 1'b1;
    @(negedge clk);
    chk("R1", "excp after release", 32'(excp), 0);
    base = 32'h0010_0000; mask = 19'h003FF;
    wr_seg(4'd3, 32'h4012_3456);
    wr_seg(4'd5, 32'h1000_0001);
    wr_seg(4'd7, 32'hA000_0000);

    // R6 fetch miss, supervisor key = 1
    req1(32'h3ABC_D000, 2'd2, 1'b0, 1'b0, 1'b1);
    chk("R6", "fetch miss class", 32'(excp), 1);
    chk("R6", "fetch miss err", err, 32'h000C_0000);
    chk("R6", "fetch miss far", far, 32'h3ABC_D000);
    chk("R6", "fetch miss cmp", cmpw, 32'h891A_2B2A);
    chk("R3", "tag", 32'(tag), 32'h091A_2B2A);
    chk("R4", "grp1", g1, 32'h0010_E6C0);
    chk("R4", "grp2", g2, 32'h0010_1900);
    // R12 hold and refuse
    req1(32'h3000_0000, 2'd0, 1'b0, 1'b1, 1'b1);
    chk("R12", "refused done", 32'(done), 0);
    chk("R12", "held fault", 32'(fault), 1);
    chk("R12", "held far", far, 32'h3ABC_D000);
    ack1();
    chk("R12", "cleared", 32'(fault), 0);

    // R7 user store miss, key = user key = 0
    req1(32'h3ABC_D000, 2'd1, 1'b1, 1'b0, 1'b1);
    chk("R7", "store miss class", 32'(excp), 3);
    chk("R7", "store miss err", err, 32'h0001_0000);
    chk("R2", "user key", 32'(key), 0);
    ack1();
    req1(32'h3ABC_D000, 2'd0, 1'b0, 1'b0, 1'b1);
    chk("R7", "load miss err", err, 32'h0008_0000);
    chk("R7", "load miss class", 32'(excp), 2);
    ack1();

    // R8 data and fetch protection
    req1(32'h3000_1000, 2'd1, 1'b0, 1'b1, 1'b0);
    chk("R8", "store prot stat", stat, 32'h0A00_0000);
    chk("R8", "store prot class", 32'(excp), 5);
    ack1();
    req1(32'h3000_1000, 2'd0, 1'b0, 1'b1, 1'b0);
    chk("R8", "load prot stat", stat, 32'h0800_0000);
    ack1();
    req1(32'h3000_1000, 2'd2, 1'b0, 1'b1, 1'b0);
    chk("R8", "fetch prot err", err, 32'h0800_0000);
    ack1();

    // R9 clean hit
    req1(32'h3000_2000, 2'd0, 1'b1, 1'b1, 1'b1);
    chk("R9", "ok fault", 32'(fault), 0);
    chk("R9", "ok done", 32'(done), 1);

    // R5 no-execute ignores lookup
    req1(32'h5000_0000, 2'd2, 1'b0, 1'b1, 1'b1);
    chk("R5", "noexec class", 32'(excp), 4);
    chk("R5", "noexec err", err, 32'h1000_0000);
    ack1();
    req1(32'h7000_0000, 2'd2, 1'b1, 1'b0, 1'b0);
    chk("R5", "ds fetch err", err, 32'h1000_0000);
    ack1();

    // R10 direct-store data, user key = 1
    req1(32'h7000_4000, 2'd1, 1'b1, 1'b0, 1'b0);
    chk("R10", "ds store ok", 32'(ds), 1);
    chk("R10", "ds store no fault", 32'(fault), 0);
    req1(32'h7000_4000, 2'd0, 1'b1, 1'b1, 1'b1);
    chk("R10", "ds load refused", 32'(excp), 5);
    chk("R10", "ds load stat", stat, 32'h0800_0000);
    ack1();

    // R13 write and request in the same cycle
    @(negedge clk); we = 1; widx = 4'd9; wdata = 32'h4000_0000;
    req = 1; ea = 32'h9000_0000; acc = 2'd0; usr = 1'b0; hit = 1; pok = 1;
    @(negedge clk); we = 0; req = 0;
    chk("R13", "old contents key", 32'(key), 0);
    req1(32'h9000_0000, 2'd0, 1'b0, 1'b1, 1'b1);
    chk("R13", "new contents key", 32'(key), 1);

    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      req  = ($urandom % 3) != 0;
      ea   = $urandom;
      acc  = 2'($urandom);
      usr  = 1'($urandom);
      hit  = ($urandom % 4) != 0;
      pok  = ($urandom % 4) != 0;
      ack  = ($urandom % 3) == 0;
      we   = ($urandom % 8) == 0;
      widx = 4'($urandom);
      wdata = $urandom;
      if (($urandom % 64) == 0) begin base = $urandom; mask = 19'($urandom); end
    end
    @(negedge clk); req = 0; we = 0; ack = 1;
    @(negedge clk); ack = 0;
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule